// File: doc/BRIEF.md
# Watermark Result Buffer with Drain-to-Empty Interrupt

This block sits between a converter core and a serial readout front end. Each time the converter finishes a conversion, it presents a result word with a channel tag and a one-cycle valid strobe. The buffer stores these pairs in arrival order, so the host controller can stay asleep until a batch has built up.

A programmable threshold decides when the host is woken. When the number of stored results reaches the threshold, the interrupt output goes high. It stays high until the host has read every entry, even after the fill level has dropped back below the threshold. A threshold of zero stops any new interrupt from being raised.

When a result arrives while every slot is full and no read happens in the same cycle, that result is discarded. The block then sets a sticky overflow flag and increments a saturating count of lost results. On the read side, the oldest entry is always visible together with an empty flag (first-word-fall-through), and a pop strobe moves to the next entry.

Top module: `wm_fifo`

## Requirements
- R1: After reset the buffer reports empty, the fill level is 0, and the interrupt, the overflow flag and the lost count are all 0.
- R2: Whenever the empty flag is low, the read data and tag show the oldest stored entry. A pop on one clock edge shows the next entry after that edge, so entries leave in the order they were written.
- R3: The fill level goes up by one for each accepted write and down by one for each pop made while the buffer is not empty. A pop made while the buffer is empty is ignored.
- R4: With a nonzero threshold, the interrupt goes high on the same clock edge at which the fill level first becomes greater than or equal to the threshold.
- R5: Once high, the interrupt stays high until the edge at which the fill level becomes 0, even when the fill level has fallen below the threshold.
- R6: A threshold value of 0 never raises the interrupt, however full the buffer is.
- R7: The threshold input is compared on every cycle. Changing it to a nonzero value at or below the current fill level raises the interrupt at the next edge, with no write needed.
- R8: A write made while the buffer is full and no pop is made is discarded. Stored contents and the fill level stay unchanged, and the overflow flag goes high and stays high until reset.
- R9: Each discarded write adds one to the lost count, which stops at its maximum value (255 with the defaults).
- R10: A write and a pop made in the same cycle while the buffer is full are both accepted. The fill level stays at full, the written entry is stored, and neither the overflow flag nor the lost count changes.
- R11: With the default depth of 256, a threshold of 256 is supported. The interrupt goes high exactly when the 256th entry is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A result is presented this cycle |
| in_data | input | DATA_W | Result word |
| in_tag | input | TAG_W | Channel tag of the result |
| wm | input | CW | Interrupt threshold, 0 disables it |
| out_pop | input | 1 | Remove the oldest entry |
| out_data | output | DATA_W | Oldest entry's result word |
| out_tag | output | TAG_W | Oldest entry's channel tag |
| out_empty | output | 1 | No entries stored |
| fill | output | CW | Number of stored entries |
| irq | output | 1 | Threshold interrupt, held until drained |
| ovf | output | 1 | Sticky overflow flag |
| lost | output | LOST_W | Saturating count of discarded results |

## Verification
The embedded properties take for granted that the inputs change only between clock edges, never carry unknown values after reset, and that the threshold never exceeds the depth. The bench drives every input just after a rising edge, with fixed values, and only ever programs thresholds between 0 and 256. The interrupt property compares against the threshold sampled on the previous edge, so the bench may change the threshold between any two cycles, including while the buffer holds data. Overflow and saturation are reached by pushing hundreds of results into a full buffer without popping.

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 256,
  parameter int LOST_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [CW-1:0]     wm,
  input  logic              out_pop,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_empty,
  output logic [CW-1:0]     fill,
  output logic              irq,
  output logic              ovf,
  output logic [LOST_W-1:0] lost
);

  localparam int EW = DATA_W + TAG_W;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          irq_q, ovf_q;
  logic [LOST_W-1:0] lost_q;

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire do_pop  = out_pop && !empty;
  wire do_push = in_valid && (!full || do_pop);
  wire drop    = in_valid && full && !do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= {in_tag, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      lost_q <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt_nxt;
      if (cnt_nxt == '0)
        irq_q <= 1'b0;
      else if (wm != '0 && cnt_nxt >= wm)
        irq_q <= 1'b1;
      if (drop) begin
        ovf_q <= 1'b1;
        if (lost_q != '1) lost_q <= lost_q + 1'b1;
      end
    end
  end

  assign {out_tag, out_data} = mem[rp];
  assign out_empty = empty;
  assign fill      = cnt;
  assign irq       = irq_q;
  assign ovf       = ovf_q;
  assign lost      = lost_q;

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_pop) |=> $stable(fill));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_empty && out_pop && !in_valid) |=> (fill == '0));

  // R4
  wm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wm) != '0 && fill >= $past(wm)) |-> irq);

  // R5
  irq_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && fill != '0) |=> (irq || fill == '0));

  // R5
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_empty |-> !irq);

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill == CW'(DEPTH) && !out_pop) |=> (ovf && fill == CW'(DEPTH)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);

  // R9
  lost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill == CW'(DEPTH) && !out_pop && lost != '1) |=> (lost == $past(lost) + 1'b1));

  // R10
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_pop && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH) && $stable(lost) && $stable(ovf)));

endmodule

// File: tb/sim_wm_fifo.sv
`timescale 1ns/1ps
module sim_wm_fifo;
  localparam int DEPTH = 256;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [3:0] in_tag = '0;
  logic [CW-1:0] wm = '0;
  logic out_pop = 1'b0;
  logic [15:0] out_data;
  logic [3:0] out_tag;
  logic out_empty, irq, ovf;
  logic [CW-1:0] fill;
  logic [7:0] lost;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [19:0] q[$];
  bit m_irq = 0;
  bit m_ovf = 0;
  int m_lost = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  wm_fifo u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_tag(in_tag), .wm(wm), .out_pop(out_pop), .out_data(out_data),
    .out_tag(out_tag), .out_empty(out_empty), .fill(fill), .irq(irq),
    .ovf(ovf), .lost(lost)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(out_empty == (q.size() == 0), req, "empty", int'(out_empty), int'(q.size() == 0));
    chk(int'(fill) == q.size(), req, "fill", int'(fill), q.size());
    if (q.size() != 0)
      chk({out_tag, out_data} == q[0], req, "head", int'({out_tag, out_data}), int'(q[0]));
    chk(irq == m_irq, req, "irq", int'(irq), int'(m_irq));
    chk(ovf == m_ovf, req, "ovf", int'(ovf), int'(m_ovf));
    chk(int'(lost) == m_lost, req, "lost", int'(lost), m_lost);
  endtask

  task automatic cyc(input bit v, input logic [15:0] d, input logic [3:0] t, input bit p, input string req);
    int w;
    bit popok, fullq;
    in_valid = v; in_data = d; in_tag = t; out_pop = p;
    w = int'(wm);
    @(posedge clk);
    #1;
    popok = p && (q.size() != 0);
    fullq = (q.size() == DEPTH);
    if (popok) void'(q.pop_front());
    if (v && (!fullq || popok)) q.push_back({t, d});
    if (v && fullq && !popok) begin
      m_ovf = 1;
      if (m_lost < 255) m_lost++;
    end
    if (q.size() == 0) m_irq = 0;
    else if (w != 0 && q.size() >= w) m_irq = 1;
    in_valid = 1'b0; out_pop = 1'b0;
    compare(req);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic drain(input string req);
    while (q.size() != 0) cyc(0, '0, '0, 1, req);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    compare("R1");

    wm = 4;
    for (int i = 0; i < 3; i++) cyc(1, 16'h1000 + 16'(i), 4'(i), 0, "R4");
    chk(!irq, "R4", "below wm", int'(irq), 0);
    cyc(1, 16'h2222, 4'h7, 0, "R4");
    chk(irq, "R4", "at wm", int'(irq), 1);
    cyc(0, '0, '0, 1, "R2");
    cyc(0, '0, '0, 1, "R5");
    chk(irq, "R5", "held below wm", int'(irq), 1);
    cyc(0, '0, '0, 1, "R5");
    cyc(0, '0, '0, 1, "R5");
    chk(!irq, "R5", "cleared at empty", int'(irq), 0);
    cyc(0, '0, '0, 1, "R3");
    cyc(0, '0, '0, 1, "R3");
    chk(fill == 0, "R3", "pop on empty", int'(fill), 0);

    wm = 0;
    for (int i = 0; i < 10; i++) cyc(1, 16'h3000 + 16'(i), 4'hA, 0, "R6");
    chk(!irq, "R6", "wm zero", int'(irq), 0);
    wm = 5;
    cyc(0, '0, '0, 0, "R7");
    chk(irq, "R7", "wm lowered", int'(irq), 1);
    drain("R5");

    wm = 256;
    for (int i = 0; i < DEPTH; i++) begin
      lfsr = nxt(lfsr);
      cyc(1, lfsr, lfsr[3:0], 0, "R11");
      if (i == DEPTH - 2) chk(!irq, "R11", "255 stored", int'(irq), 0);
    end
    chk(irq, "R11", "256 stored", int'(irq), 1);
    for (int i = 0; i < 300; i++) cyc(1, 16'hDEAD, 4'hF, 0, "R8");
    chk(ovf, "R8", "sticky", int'(ovf), 1);
    chk(lost == 8'hFF, "R9", "saturated", int'(lost), 255);
    for (int i = 0; i < 5; i++) cyc(1, 16'h5000 + 16'(i), 4'h5, 1, "R10");
    chk(fill == CW'(DEPTH), "R10", "still full", int'(fill), DEPTH);
    while (q.size() != 0) begin
      lfsr = nxt(lfsr);
      cyc(lfsr[0] & lfsr[5], lfsr, lfsr[7:4], 1, "R2");
    end
    chk(!irq, "R5", "drained", int'(irq), 0);

    wm = 7;
    for (int i = 0; i < 2000; i++) begin
      lfsr = nxt(lfsr);
      cyc(lfsr[1] | lfsr[9], lfsr, lfsr[11:8], lfsr[2] & lfsr[14], "R3");
    end
    drain("R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule